// File: doc/BRIEF.md
# Eight-Output Addressable Latch with Decoder Mode

This block holds eight single-bit storage cells that share one serial data input. A 3-bit select picks the cell that may change, an active-low enable opens the bank for an update, and an active-low clear either empties the bank or, when the bank is enabled, turns it into a one-hot decoder. Every rising edge of the system clock samples all control and data inputs. The block then updates its eight registered outputs according to the mode that the enable and clear pins select.

The four modes are as follows. Addressed write stores the data bit into the selected cell and leaves the other seven cells unchanged. Hold freezes all cells. Clear-all forces every cell to zero. Decoder mode drives the selected output to the data bit and forces every other output low. The select inputs should change only while enable is inactive. The model holds the bank steady whenever enable is high, so a change of select at that time has no effect.

Top module: `addr_latch8`

## Requirements
- R1: While `rst` is high at a rising clock edge, all eight outputs become 0 on that edge.
- R2: With `en_n`=0 and `clr_n`=1 (addressed write), after the edge the output bit at index `sel` equals the `din` value sampled on that edge.
- R3: During an addressed write, every output bit other than the one at index `sel` keeps its previous value.
- R4: With `en_n`=1 and `clr_n`=1 (hold), all outputs keep their values on the edge, whatever `din` and `sel` do.
- R5: With `en_n`=1 and `clr_n`=0 (clear-all), all eight outputs become 0 on the edge.
- R6: With `en_n`=0 and `clr_n`=0 (decoder), after the edge the output at index `sel` equals the sampled `din` and every other output is 0.
- R7: The select value n, read as an unsigned number with bit 2 as the MSB, addresses output bit n of `q`. So 3'b000 is `q[0]` and 3'b111 is `q[7]`.
- R8: When the bank moves from decoder mode to hold, the last decoded pattern stays on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Shared data bit |
| sel | input | 3 | Cell select, unsigned index |
| en_n | input | 1 | Bank enable, active low |
| clr_n | input | 1 | Clear / decoder control, active low |
| q | output | 8 | Registered cell outputs, bit n is cell n |

## Verification
The hardest case to reach is a decoded one-hot pattern that must survive a move into hold while the select and data inputs keep changing. From the ports this looks exactly like a stuck decoder. The stimulus first decodes onto a known cell. It then raises enable, drives new select and data values on every cycle of the hold, and compares the outputs against a behavioural model each cycle. A second sequence fills the bank with mixed values through addressed writes before it enters decoder mode. This shows that decoder mode wipes the unselected cells, which clear-all alone would not reveal.

// File: rtl/latch_pkg.sv
package latch_pkg;

    parameter int SEL_W = 3;
    localparam int CELLS = 1 << SEL_W;

    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,
        MODE_WRITE  = 2'd1,
        MODE_CLEAR  = 2'd2,
        MODE_DECODE = 2'd3
    } bank_mode_e;

    typedef struct packed {
        bank_mode_e mode;
        logic       bit_in;
    } cell_ctrl_t;

    // Control pins are active low; the pair selects one of four modes.
    function automatic bank_mode_e mode_of(input logic en_n, input logic clr_n);
        bank_mode_e m;
        unique case ({en_n, clr_n})
            2'b01:   m = MODE_WRITE;
            2'b11:   m = MODE_HOLD;
            2'b10:   m = MODE_CLEAR;
            default: m = MODE_DECODE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lat_mode_dec.sv
module lat_mode_dec
    import latch_pkg::*;
(
    input  logic       en_n,
    input  logic       clr_n,
    input  logic       din,
    output cell_ctrl_t ctrl
);
    always_comb begin
        ctrl.mode   = mode_of(en_n, clr_n);
        ctrl.bit_in = din;
    end
endmodule

// File: rtl/lat_cell.sv
module lat_cell
    import latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_ctrl_t ctrl,
    input  logic       hit,
    output logic       q
);
    logic q_nxt;

    always_comb begin
        unique case (ctrl.mode)
            MODE_WRITE:  q_nxt = hit ? ctrl.bit_in : q;
            MODE_CLEAR:  q_nxt = 1'b0;
            MODE_DECODE: q_nxt = hit & ctrl.bit_in;
            default:     q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q_nxt;
    end
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
    import latch_pkg::*;
#(
    parameter int SW = SEL_W,
    localparam int N = 1 << SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din,
    input  logic [SW-1:0] sel,
    input  logic          en_n,
    input  logic          clr_n,
    output logic [N-1:0]  q
);
    cell_ctrl_t      ctrl;
    logic [N-1:0]    hit;

    lat_mode_dec i_dec (
        .en_n  (en_n),
        .clr_n (clr_n),
        .din   (din),
        .ctrl  (ctrl)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        assign hit[i] = (sel == SW'(i));
        lat_cell i_cell (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl),
            .hit  (hit[i]),
            .q    (q[i])
        );
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (q == '0)); // R1
    AST_WRITE_BIT: assert property (@(posedge clk) disable iff (rst)
        (!en_n && clr_n) |=> (q[$past(sel)] == $past(din))); // R2
    AST_WRITE_OTHERS: assert property (@(posedge clk) disable iff (rst)
        (!en_n && clr_n) |=> (((q ^ $past(q)) & ~(N'(1) << $past(sel))) == '0)); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (en_n && clr_n) |=> $stable(q)); // R4
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (en_n && !clr_n) |=> (q == '0)); // R5
    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !clr_n) |=> ($onehot0(q) && ((q & ~(N'(1) << $past(sel))) == '0))); // R6
    AST_DECODE_BIT: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !clr_n) |=> (q[$past(sel)] == $past(din))); // R6 R7
endmodule

// File: tb/test_addr_latch8.sv
module test_addr_latch8;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] q;

    int errors = 0;
    int checks = 0;
    logic [7:0] mdl = 8'h00;

    always #2.5 clk = ~clk;

    addr_latch8 i_addr_latch8 (
        .clk(clk), .rst(rst), .din(din), .sel(sel),
        .en_n(en_n), .clr_n(clr_n), .q(q)
    );

    task automatic check(input string tag, input logic [7:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%02h expected %02h", tag, q, exp);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, compare after the edge.
    task automatic step(input string tag, input logic e, input logic c,
                        input logic [2:0] a, input logic d);
        en_n = e; clr_n = c; sel = a; din = d;
        @(posedge clk);
        case ({e, c})
            2'b01: mdl[a] = d;
            2'b10: mdl = 8'h00;
            2'b00: begin mdl = 8'h00; mdl[a] = d; end
            default: ;
        endcase
        @(negedge clk);
        check(tag, mdl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 8'h00);
        rst = 1'b0;

        // R7: single write maps select n to bit n
        step("R7", 0, 1, 3'd5, 1);
        check("R7", 8'h20);
        step("R7", 0, 1, 3'd0, 1);
        check("R7", 8'h21);
        step("R7", 0, 1, 3'd7, 1);
        check("R7", 8'hA1);
        // R2/R3: overwrite one cell, others untouched
        step("R2", 0, 1, 3'd5, 0);
        check("R3", 8'h81);
        step("R3", 0, 1, 3'd3, 1);
        // R4: hold while select and data churn
        for (int i = 0; i < 8; i++) step("R4", 1, 1, 3'(i), i[0]);
        check("R4", 8'h89);
        // R6: decoder wipes the rest
        step("R6", 0, 0, 3'd2, 1);
        check("R6", 8'h04);
        step("R6", 0, 0, 3'd6, 0);
        check("R6", 8'h00);
        step("R6", 0, 0, 3'd6, 1);
        // R8: decoded pattern persists in hold
        for (int i = 0; i < 6; i++) step("R8", 1, 1, 3'(7 - i), ~i[0]);
        check("R8", 8'h40);
        // R5: clear-all
        step("R2", 0, 1, 3'd1, 1);
        step("R5", 1, 0, 3'd1, 1);
        check("R5", 8'h00);
        // Mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [1:0] m = 2'($urandom_range(0, 3));
            step("R2 R3 R4 R5 R6", m[1], m[0], 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        end
        // R1: reset mid-run
        step("R2", 0, 1, 3'd4, 1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        mdl = 8'h00;
        check("R1", 8'h00);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: q=%02h expected completion", q);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule